// File: doc/BRIEF.md
# Isolated memory region access filter

This block sits in front of a memory and checks every transaction against a bank of programmable protection regions. Each region holds an address window of 1 KiB blocks and two permission masks, one for reads and one for writes. Each mask bit stands for one requesting agent or transaction type. Software programs the regions through a small word-addressed register port. A region can be frozen with a one-way lock that only a reset clears.

A transaction carries an address, a direction flag and a one-hot agent code. One cycle later the block answers with allow or deny. On a denied write the memory write enable stays low, so the data is dropped. On a denied read the returned data is replaced by all ones. The first denial raises a sticky reset-request output. It also records the address, the agent code and the direction of that transaction in read-only status words. Regions may overlap, and a single denying region is enough to block a transaction.

Top module: `memguard_filter`

## Requirements
- R1: After reset, every region reads back low address 0, high address 0, read mask 0xBFFFFFFF and write mask 0xFFFFFFFF. The reset-request output is low and the status flags word reads 0. A region holding these values grants every agent in both directions.
- R2: Region n occupies register word offsets 0x40+4n to 0x43+4n. The words are, in order: low address, high address, read mask, write mask. The address words keep only bits 23:2, and all other bits read 0, except bit 31 of the low word, which is the lock flag. The mask words keep all 32 bits. Unmapped offsets read 0.
- R3: A region is hit when the physical address is at or above (low word << 8) and at or below (high word << 8) + 0x3FF. Only address bits 31:10 take part in the comparison, so the top block is inclusive.
- R4: The agent code is one-hot, using these bit positions: 0 CPU normal mode, 1 CPU management mode, 8-11 channel-0 IDs, 12-15 channel-1 IDs, 29 management unit, 30 dirty-snoop writeback, 31 flush. A read is denied when a hitting region has the agent's bit clear in its read mask. A write is denied when a hitting region has the agent's bit clear in its write mask. Bit 30 of the read mask is ignored for reads.
- R5: When regions overlap, a transaction is denied if any hitting region denies it, even if another hitting region allows it.
- R6: A write to an unlocked low word with bit 31 set only sets the lock, and the stored address bits are left unchanged. A write with bit 31 clear programs the address. Only reset clears the lock.
- R7: While a region is locked, writes to any of its four words are ignored and reads still return the current values. Its filtering continues unchanged.
- R8: An allowed write drives mem_wr_en high, with mem_wdata equal to the transaction data, in the response cycle. A denied write keeps mem_wr_en low.
- R9: In the response cycle of a read, rd_data equals mem_rdata if the read is allowed and 0xFFFFFFFF if it is denied.
- R10: resp_valid and resp_allow appear exactly one clock after the transaction is presented, and resp_valid is low otherwise.
- R11: viol_reset rises in the response cycle of the first denied transaction and stays high until reset.
- R12: The first denied transaction is recorded in three status words. Offset 0x60 holds the address and offset 0x61 holds the agent code. Offset 0x62 holds bit 0 = recorded and bit 1 = was a write. Later denials do not change these words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_addr | input | 32 | Transaction physical byte address |
| txn_write | input | 1 | 1 for write, 0 for read |
| txn_agent | input | 32 | One-hot agent / transaction-type code |
| txn_wdata | input | 32 | Write data of the transaction |
| resp_valid | output | 1 | Decision valid, one cycle after txn_valid |
| resp_allow | output | 1 | 1 = allowed, 0 = denied |
| mem_wr_en | output | 1 | Write enable toward memory (allowed writes only) |
| mem_wdata | output | 32 | Write data toward memory |
| mem_rdata | input | 32 | Read data from memory, aligned with the response cycle |
| rd_data | output | 32 | Read data returned to the requester |
| viol_reset | output | 1 | Sticky system reset request |

## Verification
The decision outputs resp_valid, resp_allow and mem_wr_en, the flag viol_reset and the status words all update on the single clock edge after a transaction. The bench presents a transaction on a falling edge and samples these outputs on the next falling edge. rd_data and cfg_rdata are combinational, so they are sampled a short delay after their inputs settle. Register writes take effect on the following rising edge, and their read-back is checked after that edge. Checks of lock behaviour read registers back through the port and also drive transactions through the locked region.

// File: rtl/imf_pkg.sv
package imf_pkg;
   localparam int IMF_DATA_W    = 32;
   localparam int IMF_ADDR_SHIFT = 8;   // physical address = register value << 8
   localparam int IMF_SNOOP_POS = 30;   // write-only agent bit
   localparam logic [IMF_DATA_W-1:0] IMF_RMASK_RST = 32'hBFFF_FFFF;
   localparam logic [IMF_DATA_W-1:0] IMF_WMASK_RST = 32'hFFFF_FFFF;

   typedef enum logic [1:0] {
      SEL_LO    = 2'd0,
      SEL_HI    = 2'd1,
      SEL_RMASK = 2'd2,
      SEL_WMASK = 2'd3
   } imf_sel_e;
endpackage

// File: rtl/imf_region.sv
module imf_region
   import imf_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int GRAN_LSB = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            sel,
   input  logic [IMF_DATA_W-1:0] wdata,
   output logic [IMF_DATA_W-1:0] rdata,
   input  logic [ADDR_W-GRAN_LSB-1:0] blk,
   input  logic                  is_write,
   input  logic [IMF_DATA_W-1:0] agent,
   output logic                  deny
);
   localparam int BLK_W   = ADDR_W - GRAN_LSB;
   localparam int FLD_LSB = GRAN_LSB - IMF_ADDR_SHIFT;
   localparam int PAD_HI  = IMF_DATA_W - FLD_LSB - BLK_W;
   localparam logic [IMF_DATA_W-1:0] SNOOP_BIT = IMF_DATA_W'(1) << IMF_SNOOP_POS;

   logic [BLK_W-1:0]      lo_q, hi_q;
   logic                  lock_q;
   logic [IMF_DATA_W-1:0] rmask_q, wmask_q;
   logic [IMF_DATA_W-1:0] perm;
   logic                  hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= '0;
         hi_q    <= '0;
         lock_q  <= 1'b0;
         rmask_q <= IMF_RMASK_RST;
         wmask_q <= IMF_WMASK_RST;
      end else if (wr_en && !lock_q) begin
         unique case (imf_sel_e'(sel))
            SEL_LO: begin
               if (wdata[IMF_DATA_W-1]) lock_q <= 1'b1;
               else                     lo_q   <= wdata[FLD_LSB +: BLK_W];
            end
            SEL_HI:    hi_q    <= wdata[FLD_LSB +: BLK_W];
            SEL_RMASK: rmask_q <= wdata;
            SEL_WMASK: wmask_q <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (imf_sel_e'(sel))
         SEL_LO:    rdata = {lock_q, {(PAD_HI-1){1'b0}}, lo_q, {FLD_LSB{1'b0}}};
         SEL_HI:    rdata = {{PAD_HI{1'b0}}, hi_q, {FLD_LSB{1'b0}}};
         SEL_RMASK: rdata = rmask_q;
         SEL_WMASK: rdata = wmask_q;
         default:   rdata = '0;
      endcase
   end

   assign hit  = (blk >= lo_q) && (blk <= hi_q);
   assign perm = is_write ? wmask_q : (rmask_q | SNOOP_BIT);
   assign deny = hit && ((agent & perm) == '0);

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q); // R6

   AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && wr_en) |=> ($stable(lo_q) && $stable(hi_q) &&
                             $stable(rmask_q) && $stable(wmask_q))); // R7
endmodule

// File: rtl/imf_status.sv
module imf_status
   import imf_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  evt,
   input  logic [ADDR_W-1:0]     evt_addr,
   input  logic [IMF_DATA_W-1:0] evt_agent,
   input  logic                  evt_write,
   output logic                  captured,
   output logic [ADDR_W-1:0]     cap_addr,
   output logic [IMF_DATA_W-1:0] cap_agent,
   output logic                  cap_write
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         captured  <= 1'b0;
         cap_addr  <= '0;
         cap_agent <= '0;
         cap_write <= 1'b0;
      end else if (evt && !captured) begin
         captured  <= 1'b1;
         cap_addr  <= evt_addr;
         cap_agent <= evt_agent;
         cap_write <= evt_write;
      end
   end

   AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      captured |=> ($stable(cap_addr) && $stable(cap_agent) && $stable(cap_write))); // R12
endmodule

// File: rtl/memguard_filter.sv
module memguard_filter
   import imf_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 32,
   parameter int GRAN_LSB    = 10,
   parameter int CFG_AW      = 8,
   parameter int BASE_OFF    = 'h40
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr,
   input  logic [CFG_AW-1:0]     cfg_addr,
   input  logic [IMF_DATA_W-1:0] cfg_wdata,
   output logic [IMF_DATA_W-1:0] cfg_rdata,
   input  logic                  txn_valid,
   input  logic [ADDR_W-1:0]     txn_addr,
   input  logic                  txn_write,
   input  logic [IMF_DATA_W-1:0] txn_agent,
   input  logic [IMF_DATA_W-1:0] txn_wdata,
   output logic                  resp_valid,
   output logic                  resp_allow,
   output logic                  mem_wr_en,
   output logic [IMF_DATA_W-1:0] mem_wdata,
   input  logic [IMF_DATA_W-1:0] mem_rdata,
   output logic [IMF_DATA_W-1:0] rd_data,
   output logic                  viol_reset
);
   localparam int BLK_W    = ADDR_W - GRAN_LSB;
   localparam int STAT_OFF = BASE_OFF + 4 * NUM_REGIONS;
   localparam logic [CFG_AW-1:0] STAT_A   = CFG_AW'(STAT_OFF);
   localparam logic [CFG_AW-3:0] BASE_W4  = (CFG_AW-2)'(BASE_OFF / 4);

   // elaboration-time parameter checks
   if (NUM_REGIONS < 1)                       begin : g_chk_n   $error("NUM_REGIONS must be at least 1"); end
   if ((BASE_OFF % 4) != 0)                   begin : g_chk_al  $error("BASE_OFF must be word-group aligned"); end
   if (STAT_OFF + 3 > (1 << CFG_AW))          begin : g_chk_sp  $error("register map exceeds CFG_AW"); end
   if (ADDR_W != IMF_DATA_W)                  begin : g_chk_aw  $error("ADDR_W must equal the register width"); end
   if (GRAN_LSB - IMF_ADDR_SHIFT + BLK_W >= IMF_DATA_W)
                                              begin : g_chk_fld $error("address field collides with lock bit"); end

   logic [NUM_REGIONS-1:0] deny_vec;
   logic [NUM_REGIONS-1:0] rgn_sel;
   logic [IMF_DATA_W-1:0]  rgn_rdata [NUM_REGIONS];
   logic [IMF_DATA_W-1:0]  bank_rdata;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
      assign rgn_sel[g] = (cfg_addr[CFG_AW-1:2] == BASE_W4 + (CFG_AW-2)'(g));
      imf_region #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) rgn_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (cfg_wr && rgn_sel[g]),
         .sel      (cfg_addr[1:0]),
         .wdata    (cfg_wdata),
         .rdata    (rgn_rdata[g]),
         .blk      (txn_addr[ADDR_W-1:GRAN_LSB]),
         .is_write (txn_write),
         .agent    (txn_agent),
         .deny     (deny_vec[g])
      );
   end

   always_comb begin
      bank_rdata = '0;
      for (int i = 0; i < NUM_REGIONS; i++)
         if (rgn_sel[i]) bank_rdata = bank_rdata | rgn_rdata[i];
   end

   // decision register
   logic                  deny_any;
   logic                  vld_q, allow_q, write_q;
   logic [IMF_DATA_W-1:0] wdata_q;

   assign deny_any = |deny_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         allow_q <= 1'b0;
         write_q <= 1'b0;
         wdata_q <= '0;
      end else begin
         vld_q   <= txn_valid;
         allow_q <= txn_valid && !deny_any;
         write_q <= txn_valid && txn_write;
         wdata_q <= txn_wdata;
      end
   end

   assign resp_valid = vld_q;
   assign resp_allow = allow_q;
   assign mem_wr_en  = vld_q && write_q && allow_q;
   assign mem_wdata  = wdata_q;
   assign rd_data    = (vld_q && !allow_q) ? '1 : mem_rdata;

   // first-violation capture
   logic                  cap_vld, cap_write;
   logic [ADDR_W-1:0]     cap_addr;
   logic [IMF_DATA_W-1:0] cap_agent;

   imf_status #(.ADDR_W(ADDR_W)) stat_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (txn_valid && deny_any),
      .evt_addr  (txn_addr),
      .evt_agent (txn_agent),
      .evt_write (txn_write),
      .captured  (cap_vld),
      .cap_addr  (cap_addr),
      .cap_agent (cap_agent),
      .cap_write (cap_write)
   );

   assign viol_reset = cap_vld;

   always_comb begin
      if (|rgn_sel)                     cfg_rdata = bank_rdata;
      else if (cfg_addr == STAT_A)      cfg_rdata = cap_addr;
      else if (cfg_addr == STAT_A + 1)  cfg_rdata = cap_agent;
      else if (cfg_addr == STAT_A + 2)  cfg_rdata = {{(IMF_DATA_W-2){1'b0}}, cap_write, cap_vld};
      else                              cfg_rdata = '0;
   end

   AST_AGENT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> ($countones(txn_agent) == 1)); // R4

   AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |=> resp_valid); // R10

   AST_DENY_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_allow) |-> !mem_wr_en); // R8

   AST_DENY_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_write && deny_any) |=> (rd_data == '1)); // R9

   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      viol_reset |=> viol_reset); // R11

   AST_VIOL_ON_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && deny_any) |=> viol_reset); // R11
endmodule

// File: tb/memguard_filter_tb_top.sv
module memguard_filter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] MEM_PAT = 32'h1234_5678;
   localparam int NVEC = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        txn_valid = 1'b0;
   logic [31:0] txn_addr = '0;
   logic        txn_write = 1'b0;
   logic [31:0] txn_agent = 32'h1;
   logic [31:0] txn_wdata = '0;
   logic        resp_valid, resp_allow, mem_wr_en, viol_reset;
   logic [31:0] mem_wdata, rd_data;
   logic [31:0] mem_rdata = MEM_PAT;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   memguard_filter dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .txn_valid(txn_valid),
      .txn_addr(txn_addr), .txn_write(txn_write), .txn_agent(txn_agent),
      .txn_wdata(txn_wdata), .resp_valid(resp_valid), .resp_allow(resp_allow),
      .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rd_data(rd_data), .viol_reset(viol_reset)
   );

   // entry = {addr[31:0], write, agent[31:0], expected allow}
   // region A: 0x1000..0x1FFF, rmask 0x1, wmask 0x1
   // region B: 0x1800..0x27FF, rmask 0x3, wmask 0x2
   localparam logic [65:0] VEC [NVEC] = '{
      {32'h0000_0FFC, 1'b0, 32'h0000_0002, 1'b1},  // below A, no hit
      {32'h0000_1000, 1'b0, 32'h0000_0002, 1'b0},  // A low edge, mode bit clear (first violation)
      {32'h0000_1000, 1'b0, 32'h0000_0001, 1'b1},
      {32'h0000_17FC, 1'b0, 32'h0000_0001, 1'b1},  // A only
      {32'h0000_1400, 1'b1, 32'h0000_0001, 1'b1},
      {32'h0000_1800, 1'b1, 32'h0000_0001, 1'b0},  // overlap: B denies
      {32'h0000_1800, 1'b1, 32'h0000_0002, 1'b0},  // overlap: A denies
      {32'h0000_1FFF, 1'b0, 32'h0000_0002, 1'b0},  // A inclusive top
      {32'h0000_2000, 1'b0, 32'h0000_0002, 1'b1},  // B only
      {32'h0000_27FF, 1'b0, 32'h0000_0001, 1'b1},  // B inclusive top
      {32'h0000_27FF, 1'b1, 32'h0000_0002, 1'b1},
      {32'h0000_2800, 1'b1, 32'h0000_0100, 1'b1},  // above B
      {32'h0000_0000, 1'b1, 32'h4000_0000, 1'b1},  // reset-valued regions grant
      {32'h0000_0000, 1'b0, 32'h4000_0000, 1'b1},  // read mask bit 30 ignored
      {32'h0000_2400, 1'b0, 32'h0000_0100, 1'b0}   // channel-0 read denied by B
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_check(input logic [7:0] a, input logic [31:0] exp, input string req);
      cfg_addr = a;
      #1;
      chk(cfg_rdata == exp, req, cfg_rdata, exp);
   endtask

   task automatic run_txn(input logic [31:0] a, input bit wr, input logic [31:0] ag,
                          input bit exp_allow, input string req);
      logic [31:0] wd;
      wd = a ^ 32'hA5A5_0000;
      @(negedge clk);
      txn_valid = 1'b1; txn_addr = a; txn_write = wr; txn_agent = ag; txn_wdata = wd;
      @(negedge clk);
      txn_valid = 1'b0;
      chk(resp_valid == 1'b1, "R10 resp_valid", 32'(resp_valid), 32'h1);
      chk(resp_allow == exp_allow, req, 32'(resp_allow), 32'(exp_allow));
      chk(mem_wr_en == (wr && exp_allow), "R8 mem_wr_en", 32'(mem_wr_en), 32'(wr && exp_allow));
      if (wr && exp_allow)
         chk(mem_wdata == wd, "R8 mem_wdata", mem_wdata, wd);
      if (!wr)
         chk(rd_data == (exp_allow ? MEM_PAT : 32'hFFFF_FFFF), "R9 rd_data", rd_data,
             exp_allow ? MEM_PAT : 32'hFFFF_FFFF);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int r = 0; r < 8; r++) begin
         cfg_check(8'(8'h40 + 4*r),     32'h0,         "R1 lo reset");
         cfg_check(8'(8'h40 + 4*r + 1), 32'h0,         "R1 hi reset");
         cfg_check(8'(8'h40 + 4*r + 2), 32'hBFFF_FFFF, "R1 rmask reset");
         cfg_check(8'(8'h40 + 4*r + 3), 32'hFFFF_FFFF, "R1 wmask reset");
      end
      cfg_check(8'h62, 32'h0, "R1 status flags reset");
      chk(viol_reset == 1'b0, "R1 viol_reset low", 32'(viol_reset), 32'h0);
      run_txn(32'h0000_0200, 1'b1, 32'h0000_8000, 1'b1, "R1 reset regions grant");

      // R2 programming and field masking
      cfg_write(8'h40, 32'h0F00_0013);  // region A lo, stray bits
      cfg_check(8'h40, 32'h0000_0010, "R2 lo field masking");
      cfg_write(8'h41, 32'hFF00_001C);
      cfg_check(8'h41, 32'h0000_001C, "R2 hi field masking");
      cfg_write(8'h42, 32'h0000_0001);
      cfg_write(8'h43, 32'h0000_0001);
      cfg_write(8'h44, 32'h0000_0018);  // region B
      cfg_write(8'h45, 32'h0000_0024);
      cfg_write(8'h46, 32'h0000_0003);
      cfg_write(8'h47, 32'h0000_0002);
      cfg_check(8'h46, 32'h0000_0003, "R2 region 1 rmask at 0x46");
      cfg_check(8'h47, 32'h0000_0002, "R2 region 1 wmask at 0x47");
      cfg_check(8'h3F, 32'h0, "R2 unmapped reads 0");

      // R10 no response before the edge, none in an idle cycle
      @(negedge clk);
      chk(resp_valid == 1'b0, "R10 idle no response", 32'(resp_valid), 32'h0);

      // table: R3 R4 R5 R8 R9
      for (int i = 0; i < NVEC; i++) begin
         logic [65:0] e;
         e = VEC[i];
         run_txn(e[65:34], e[33], e[32:1], e[0], $sformatf("R3/R4/R5 vector %0d allow", i));
         if (i == 0)
            chk(viol_reset == 1'b0, "R11 no request before violation", 32'(viol_reset), 32'h0);
         if (i == 1)
            chk(viol_reset == 1'b1, "R11 request on first violation", 32'(viol_reset), 32'h1);
      end
      chk(viol_reset == 1'b1, "R11 request stays high", 32'(viol_reset), 32'h1);
      @(negedge clk);
      chk(resp_valid == 1'b0, "R10 resp_valid drops", 32'(resp_valid), 32'h0);

      // R12 first violation kept
      cfg_check(8'h60, 32'h0000_1000, "R12 captured address");
      cfg_check(8'h61, 32'h0000_0002, "R12 captured agent");
      cfg_check(8'h62, 32'h0000_0001, "R12 flags recorded, read");

      // R6 lock separate from address, R7 frozen while locked
      cfg_write(8'h48, 32'h0000_0100);  // region 2 at 0x10000
      cfg_write(8'h49, 32'h0000_0100);
      cfg_write(8'h4A, 32'h0000_0000);
      cfg_write(8'h48, 32'h8000_0200);  // lock only
      cfg_check(8'h48, 32'h8000_0100, "R6 lock keeps address");
      cfg_write(8'h48, 32'h0000_0000);
      cfg_write(8'h49, 32'h0000_0300);
      cfg_write(8'h4A, 32'hFFFF_FFFF);
      cfg_write(8'h4B, 32'h0000_0000);
      cfg_check(8'h48, 32'h8000_0100, "R7 locked lo unchanged");
      cfg_check(8'h49, 32'h0000_0100, "R7 locked hi unchanged");
      cfg_check(8'h4A, 32'h0000_0000, "R7 locked rmask unchanged");
      cfg_check(8'h4B, 32'hFFFF_FFFF, "R7 locked wmask unchanged");
      run_txn(32'h0001_0000, 1'b0, 32'h0000_0001, 1'b0, "R7 locked region still denies");
      run_txn(32'h0001_0000, 1'b1, 32'h0000_0001, 1'b1, "R7 locked region write mask intact");
      cfg_check(8'h60, 32'h0000_1000, "R12 later violation ignored");

      // reset clears lock and request
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cfg_check(8'h48, 32'h0, "R6 reset clears lock");
      chk(viol_reset == 1'b0, "R11 reset clears request", 32'(viol_reset), 32'h0);
      cfg_write(8'h48, 32'h0000_0040);
      cfg_check(8'h48, 32'h0000_0040, "R6 unlocked after reset accepts write");

      // write violation direction captured
      cfg_write(8'h4F, 32'h0000_0000);  // region 3 wmask none, block 0
      run_txn(32'h0000_0004, 1'b1, 32'h2000_0000, 1'b0, "R4 mgmt write denied");
      cfg_check(8'h62, 32'h0000_0003, "R12 flags recorded, write");
      cfg_check(8'h61, 32'h2000_0000, "R12 captured agent write");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule